// File: doc/BRIEF.md
# Access Permission Checker with Bus-Fault Capture

This block judges every processor memory access before it reaches memory. For each request it takes the logical address, the direction, the access size, the processor privilege mode and the page-map entry of the addressed page. It sorts the access into one of five outcomes: allowed, page fault, user I/O error, kernel-area violation or write-protect violation. The outcome leaves on a response channel one cycle after the request is accepted. Address translation and the memory data paths are handled elsewhere.

A faulted access also raises a one-cycle bus-error pulse and writes a fault syndrome into three status registers. The general status register records the direction and cause of page and user I/O faults. Bus status 0 records the access width, the byte lane and the upper address byte. Bus status 1 records the lower address half. Software reads these registers after the bus error and resets them with a clear strobe.

Requests arrive on a valid/ready channel and results leave on a valid/ready channel. The request side is ready whenever the result register is empty or is being emptied in the same cycle. A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. A result remains on the response port, unchanged, until `resp_ready` takes it. The requester must keep its request fields stable while `req_valid` is high and `req_ready` is low.

Top module: `acc_fault_guard`

## Requirements
- R1: `req_ready` equals `!resp_valid || resp_ready`. An accepted request produces `resp_valid` at the next clock edge. While `resp_valid` is high and `resp_ready` is low, `resp_valid` and `resp_kind` stay unchanged.
- R2: When `req_super` is 1, the result is allowed (kind 0), whatever the address and map entry.
- R3: In user mode, an address of 0x400000 or above gives user I/O error (kind 2). This check has priority over all other checks.
- R4: In user mode below 0x400000, map bits [14:13] both zero give page fault (kind 1).
- R5: Otherwise, address bits [22:19] all zero give kernel violation (kind 3).
- R6: Otherwise, map bit 15 at zero gives write-protect violation (kind 4) for reads as well as for writes. In all remaining cases the result is allowed (kind 0).
- R7: The general status register is loaded on the fault-producing acceptance as follows:
  - write page fault: 0x8BFF
  - read page fault: 0xCBFF
  - write user I/O error: 0x9AFF
  - read user I/O error: 0xDAFF

  Bit 10 (0x0400) is also set when `pie` is 1.
- R8: Kernel and write-protect faults leave the general status register unchanged.
- R9: On any fault, bus status 0 is loaded with an upper byte and a lower byte. The lower byte is address bits [23:16]. The upper byte depends on the access:
  - 0x7F for size code 1 (16-bit) or size code 2 (32-bit)
  - 0x7D for a size-code-0 (byte) access to an odd address
  - 0x7E for a byte access to an even address
- R10: On any fault, bus status 1 is loaded with address bits [15:0].
- R11: `bus_err` is high for exactly the one cycle that follows the acceptance of a faulting request. It stays low for allowed requests and while a result is held.
- R12: Reset and a `clr_stat` pulse set all three status registers to 0xFFFF. A register that a fault loads in the same cycle takes the fault value instead of the cleared value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request accepted at this edge |
| req_addr | input | 24 | logical address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = 16-bit, 2 = 32-bit |
| req_super | input | 1 | processor in supervisor mode |
| req_map | input | 16 | page-map entry of the addressed page |
| pie | input | 1 | parity interrupt enable |
| clr_stat | input | 1 | clear-status write strobe |
| resp_valid | output | 1 | result present |
| resp_ready | input | 1 | result taken at this edge |
| resp_kind | output | 3 | 0 ok, 1 page, 2 user I/O, 3 kernel, 4 write-protect |
| resp_fault | output | 1 | result is a fault |
| bus_err | output | 1 | one-cycle bus-error pulse |
| gen_stat | output | 16 | general status register |
| bstat0 | output | 16 | bus status 0 |
| bstat1 | output | 16 | bus status 1 |

## Verification
The classifier is driven with supervisor accesses that carry every fault-provoking condition, to show that the mode overrides all checks. User accesses are built to trip exactly one rule at a time, and then several rules together, to show that the priority order decides. Syndromes are compared for reads against writes, `pie` on against off, and byte-odd, byte-even, 16-bit and 32-bit accesses, which separates each field of the status encodings. Back-to-back requests, a stalled response, and a clear strobe coinciding with a fault show that syndromes are neither lost nor overwritten by the wrong event.

// File: rtl/acc_chk_pkg.sv
package acc_chk_pkg;
  localparam int ADDR_W = 24;
  localparam int MAP_W  = 16;
  localparam int STAT_W = 16;

  typedef enum logic [2:0] {
    ACC_OK    = 3'd0,
    ACC_PAGE  = 3'd1,
    ACC_UIO   = 3'd2,
    ACC_KERN  = 3'd3,
    ACC_WPROT = 3'd4
  } acc_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic              gen_load;
    logic [STAT_W-1:0] gen;
    logic [STAT_W-1:0] bs0;
    logic [STAT_W-1:0] bs1;
  } syndrome_t;
endpackage

// File: rtl/acc_classifier.sv
module acc_classifier
  import acc_chk_pkg::*;
#(
  parameter int IO_BIT   = 22,
  parameter int KERN_LO  = 19,
  parameter int KERN_HI  = 22,
  parameter int PRES_LO  = 13,
  parameter int PRES_HI  = 14,
  parameter int WREN_BIT = 15
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              super_mode,
  input  logic [MAP_W-1:0]  map_ent,
  output acc_kind_e         kind
);
  localparam int IO_W = ADDR_W - IO_BIT;

  logic io_zone, absent, kern_zone, no_wren;

  assign io_zone   = |addr[ADDR_W-1:IO_BIT];
  assign absent    = ~|map_ent[PRES_HI:PRES_LO];
  assign kern_zone = ~|addr[KERN_HI:KERN_LO];
  assign no_wren   = ~map_ent[WREN_BIT];

  // Priority: mode, I/O zone, presence, kernel area, write enable.
  always_comb begin
    if (super_mode)     kind = ACC_OK;
    else if (io_zone)   kind = ACC_UIO;
    else if (absent)    kind = ACC_PAGE;
    else if (kern_zone) kind = ACC_KERN;
    else if (no_wren)   kind = ACC_WPROT;
    else                kind = ACC_OK;
  end

  initial begin
    assert (IO_W > 0 && KERN_HI < ADDR_W && WREN_BIT < MAP_W);
  end
endmodule

// File: rtl/fault_syndrome.sv
module fault_syndrome
  import acc_chk_pkg::*;
#(
  parameter logic [STAT_W-1:0] GEN_WR_PAGE = 16'h8BFF,
  parameter logic [STAT_W-1:0] GEN_WR_UIO  = 16'h9AFF,
  parameter logic [STAT_W-1:0] GEN_RD_PAGE = 16'hCBFF,
  parameter logic [STAT_W-1:0] GEN_RD_UIO  = 16'hDAFF,
  parameter int                PIE_BIT     = 10,
  parameter logic [7:0]        LANE_WIDE   = 8'h7F,
  parameter logic [7:0]        LANE_ODD    = 8'h7D,
  parameter logic [7:0]        LANE_EVEN   = 8'h7E
) (
  input  acc_kind_e         kind,
  input  logic              write,
  input  logic [1:0]        size,
  input  logic              pie,
  input  logic [ADDR_W-1:0] addr,
  output syndrome_t         syn
);
  localparam int HI_LO = STAT_W;
  localparam int HI_W  = ADDR_W - HI_LO;

  logic [STAT_W-1:0] gen_base;
  logic [7:0]        lane;
  logic [STAT_W-1:0] pie_mask;

  always_comb begin
    pie_mask          = '0;
    pie_mask[PIE_BIT] = pie;
  end

  always_comb begin
    unique case (kind)
      ACC_PAGE: gen_base = write ? GEN_WR_PAGE : GEN_RD_PAGE;
      ACC_UIO:  gen_base = write ? GEN_WR_UIO  : GEN_RD_UIO;
      default:  gen_base = '1;
    endcase
  end

  always_comb begin
    if (size != SZ_BYTE) lane = LANE_WIDE;
    else if (addr[0])    lane = LANE_ODD;
    else                 lane = LANE_EVEN;
  end

  always_comb begin
    syn.gen_load = (kind == ACC_PAGE) || (kind == ACC_UIO);
    syn.gen      = gen_base | pie_mask;
    syn.bs0      = {lane, {(8 - HI_W){1'b0}}, addr[ADDR_W-1:HI_LO]};
    syn.bs1      = addr[STAT_W-1:0];
  end
endmodule

// File: rtl/status_bank.sv
module status_bank
  import acc_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  syndrome_t         syn,
  input  logic              clr,
  output logic [STAT_W-1:0] gen,
  output logic [STAT_W-1:0] bs0,
  output logic [STAT_W-1:0] bs1
);
  localparam logic [STAT_W-1:0] CLEARED = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      gen <= CLEARED;
      bs0 <= CLEARED;
      bs1 <= CLEARED;
    end else begin
      if (load && syn.gen_load) gen <= syn.gen;
      else if (clr)             gen <= CLEARED;
      if (load) begin
        bs0 <= syn.bs0;
        bs1 <= syn.bs1;
      end else if (clr) begin
        bs0 <= CLEARED;
        bs1 <= CLEARED;
      end
    end
  end

  // R12
  clr_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr && !load |=> gen == CLEARED && bs0 == CLEARED && bs1 == CLEARED);

  // R8
  gen_keep_chk: assert property (@(posedge clk) disable iff (rst)
    load && !syn.gen_load && !clr |=> $stable(gen));
endmodule

// File: rtl/acc_fault_guard.sv
module acc_fault_guard
  import acc_chk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_super,
  input  logic [MAP_W-1:0]  req_map,
  input  logic              pie,
  input  logic              clr_stat,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [2:0]        resp_kind,
  output logic              resp_fault,
  output logic              bus_err,
  output logic [STAT_W-1:0] gen_stat,
  output logic [STAT_W-1:0] bstat0,
  output logic [STAT_W-1:0] bstat1
);
  acc_kind_e kind_c, kind_q;
  syndrome_t syn_c;
  logic      accept, fault_c;

  acc_classifier u_class (
    .addr       (req_addr),
    .super_mode (req_super),
    .map_ent    (req_map),
    .kind       (kind_c)
  );

  fault_syndrome u_syn (
    .kind  (kind_c),
    .write (req_write),
    .size  (req_size),
    .pie   (pie),
    .addr  (req_addr),
    .syn   (syn_c)
  );

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign fault_c   = (kind_c != ACC_OK);

  status_bank u_stat (
    .clk  (clk),
    .rst  (rst),
    .load (accept && fault_c),
    .syn  (syn_c),
    .clr  (clr_stat),
    .gen  (gen_stat),
    .bs0  (bstat0),
    .bs1  (bstat1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      kind_q     <= ACC_OK;
      bus_err    <= 1'b0;
    end else begin
      bus_err <= accept && fault_c;
      if (accept) begin
        resp_valid <= 1'b1;
        kind_q     <= kind_c;
      end else if (resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end

  assign resp_kind  = kind_q;
  assign resp_fault = (kind_q != ACC_OK);

  // R1
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_kind));

  // R2
  super_ok_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_super |=> resp_valid && resp_kind == 3'd0);

  // R3
  uio_prio_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !req_super && (|req_addr[ADDR_W-1:22])
    |=> resp_kind == 3'd2);

  // R11
  berr_src_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(req_valid && req_ready));

  // R10
  bs1_cap_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> bstat1 == $past(req_addr[15:0]));
endmodule

// File: tb/acc_fault_guard_tb_top.sv
module acc_fault_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0;
  logic        pie = 1'b0, clr_stat = 1'b0, resp_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] req_map = '0;
  logic        req_ready, resp_valid, resp_fault, bus_err;
  logic [2:0]  resp_kind;
  logic [15:0] gen_stat, bstat0, bstat1;

  int n_tests = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  acc_fault_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_super(req_super), .req_map(req_map), .pie(pie), .clr_stat(clr_stat),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_kind(resp_kind),
    .resp_fault(resp_fault), .bus_err(bus_err), .gen_stat(gen_stat),
    .bstat0(bstat0), .bstat1(bstat1)
  );

  typedef struct {
    logic [2:0]  kind;
    logic [15:0] gen, bs0, bs1;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [15:0] m_gen = 16'hFFFF, m_bs0 = 16'hFFFF, m_bs1 = 16'hFFFF;
  logic        held = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] model_kind(logic [23:0] a, logic s, logic [15:0] m);
    if (s) return 3'd0;
    if (a >= 24'h400000) return 3'd2;
    if (m[14:13] == 2'b00) return 3'd1;
    if (a[22:19] == 4'd0) return 3'd3;
    if (!m[15]) return 3'd4;
    return 3'd0;
  endfunction

  task automatic send(input logic [23:0] a, input logic w, input logic [1:0] sz,
                      input logic s, input logic [15:0] m, input logic p,
                      input logic clr, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_size = sz;
    req_super = s; req_map = m; pie = p; clr_stat = clr;
    while (!req_ready) @(negedge clk);
    e.kind = model_kind(a, s, m);
    if (clr) begin m_gen = 16'hFFFF; m_bs0 = 16'hFFFF; m_bs1 = 16'hFFFF; end
    if (e.kind == 3'd1) m_gen = (w ? 16'h8BFF : 16'hCBFF) | (p ? 16'h0400 : 16'h0);
    if (e.kind == 3'd2) m_gen = (w ? 16'h9AFF : 16'hDAFF) | (p ? 16'h0400 : 16'h0);
    if (e.kind != 3'd0) begin
      m_bs0 = {(sz != 2'd0) ? 8'h7F : (a[0] ? 8'h7D : 8'h7E), a[23:16]};
      m_bs1 = a[15:0];
    end
    e.gen = m_gen; e.bs0 = m_bs0; e.bs1 = m_bs1; e.tag = tag;
    sb.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0; clr_stat = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: scoreboard compare at delivery, pulse check on first cycle
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (resp_valid && sb.size() > 0) begin
        check(bus_err == ((sb[0].kind != 3'd0) && !held),
              {sb[0].tag, " R11 bus_err"}, bus_err, (sb[0].kind != 3'd0) && !held);
        if (resp_ready) begin
          exp_t e;
          e = sb.pop_front();
          check(resp_kind == e.kind, {e.tag, " kind"}, resp_kind, e.kind);
          check(resp_fault == (e.kind != 3'd0), {e.tag, " fault"}, resp_fault, e.kind != 3'd0);
          check(gen_stat == e.gen, {e.tag, " R7 R8 gen_stat"}, gen_stat, e.gen);
          check(bstat0 == e.bs0, {e.tag, " R9 bstat0"}, bstat0, e.bs0);
          check(bstat1 == e.bs1, {e.tag, " R10 bstat1"}, bstat1, e.bs1);
        end
      end else if (!resp_valid && bus_err) begin
        check(1'b0, "R11 stray bus_err", bus_err, 0);
      end
      held = resp_valid && !resp_ready;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R12 reset state
    check(gen_stat == 16'hFFFF && bstat0 == 16'hFFFF && bstat1 == 16'hFFFF,
          "R12 reset regs", {gen_stat, bstat0}, 32'hFFFFFFFF);
    check(!resp_valid && !bus_err && req_ready, "R1 reset handshake", resp_valid, 0);

    // R2 supervisor overrides everything
    send(24'hC01234, 1'b1, 2'd0, 1'b1, 16'h0000, 1'b0, 1'b0, "R2 super io");
    send(24'h012345, 1'b1, 2'd2, 1'b1, 16'h0000, 1'b1, 1'b0, "R2 super kernel");
    // R3 user I/O, write word, then read long with pie, back-to-back
    send(24'h51234A, 1'b1, 2'd1, 1'b0, 16'hE000, 1'b0, 1'b0, "R3 uio wr");
    send(24'hE40010, 1'b0, 2'd2, 1'b0, 16'h0000, 1'b1, 1'b0, "R3 uio rd pie");
    // R4 page faults: write odd byte, read even byte with pie
    send(24'h1ABCD5, 1'b1, 2'd0, 1'b0, 16'h8000, 1'b0, 1'b0, "R4 page wr odd");
    send(24'h2F0002, 1'b0, 2'd0, 1'b0, 16'h9FFF, 1'b1, 1'b0, "R4 page rd even");
    // R4 over R5: absent page in kernel area
    send(24'h000100, 1'b0, 2'd1, 1'b0, 16'h0000, 1'b0, 1'b0, "R4 prio over kernel");
    // R5 kernel area; R8 gen unchanged
    send(24'h012346, 1'b0, 2'd1, 1'b0, 16'hE000, 1'b0, 1'b0, "R5 kernel rd");
    // R6 write-protect for write and read, then allowed
    send(24'h300001, 1'b1, 2'd0, 1'b0, 16'h6000, 1'b0, 1'b0, "R6 wprot wr");
    send(24'h300000, 1'b0, 2'd2, 1'b0, 16'h2000, 1'b1, 1'b0, "R6 wprot rd");
    send(24'h3FFFFE, 1'b1, 2'd1, 1'b0, 16'hA000, 1'b0, 1'b0, "R6 allowed");
    send(24'h080000, 1'b1, 2'd0, 1'b0, 16'hC000, 1'b0, 1'b0, "R5 boundary allowed");
    idle(3);

    // R12 clear strobe alone
    @(negedge clk); clr_stat = 1'b1;
    m_gen = 16'hFFFF; m_bs0 = 16'hFFFF; m_bs1 = 16'hFFFF;
    @(negedge clk); clr_stat = 1'b0; #1;
    check(gen_stat == 16'hFFFF && bstat0 == 16'hFFFF && bstat1 == 16'hFFFF,
          "R12 clear strobe", {gen_stat, bstat1}, 32'hFFFFFFFF);

    // R12 fault wins over a clear in the same cycle; kernel fault: gen cleared
    send(24'h1ABCD4, 1'b0, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b1, "R12 clr+page");
    send(24'h00F00F, 1'b1, 2'd0, 1'b0, 16'hE000, 1'b0, 1'b0, "R8 kernel keeps gen");
    send(24'h002222, 1'b1, 2'd1, 1'b0, 16'hE000, 1'b0, 1'b1, "R12 clr+kernel");
    idle(2);

    // R1 stall: response held, ready low
    @(negedge clk); resp_ready = 1'b0;
    send(24'h600000, 1'b1, 2'd0, 1'b0, 16'h0000, 1'b0, 1'b0, "R1 stalled uio");
    @(negedge clk);
    req_valid = 1'b1; req_super = 1'b1; req_addr = 24'h000000;
    repeat (3) begin
      @(negedge clk); #1;
      check(resp_valid && !req_ready && resp_kind == 3'd2, "R1 hold", resp_kind, 2);
    end
    req_valid = 1'b0;
    @(negedge clk); resp_ready = 1'b1;
    idle(4);
    check(sb.size() == 0, "R1 all delivered", sb.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule